// File: doc/BRIEF.md
# Four-Channel Converter Serial Register Front End

This block is the serial slave front end for a four-channel, 16-bit output converter. A host shifts 24-bit frames into it, most significant bit first, while chip-select is held low. The block samples the serial inputs with its own system clock through synchronizers. It finds the serial clock edges in that clock domain. When chip-select rises after exactly 24 bits, it commits the frame. A committed frame is either a write to a per-channel register or a read request.

A write stores a per-channel code, gain or offset word. It can also store a 13-bit control sub-register, chosen by a 3-bit selector at the top of the data field. A read needs two frames. The first frame carries the address and takes a snapshot of the register. The snapshot comes back in the low 16 bits of whatever frame the host sends next, usually the no-operation filler. All stored values are driven out of the block as flat parallel buses for the converter core.

Top module: `quad_dac_spi_if`

## Requirements
- R1: Frames are 24 bits, sampled on SCLK rising edges while CS_N is low, MSB first. Bit 23 is the read flag, bits 20:16 are the address and bits 15:0 are the data. Bits 22:21 have no effect.
- R2: A write frame (bit 23 clear) to address 0x00+ch stores the data word for channel ch (ch = address bits 1:0). Address 0x08+ch stores the gain word and 0x10+ch stores the offset word. The new value appears on the outputs after CS_N rises.
- R3: A write to 0x1C+ch is a control write. Data bits 15:13 select the sub-register and bits 12:0 are its contents. Selector 0 is the slew word of channel ch and 2 is the converter control word of channel ch. Selector 1 is the global main word and 3 is the global boost-supply word; both ignore ch. Selector 4 raises sw_strobe_o for exactly one clock, with the contents on sw_word_o. Selectors 5 to 7 change nothing.
- R4: A read frame (bit 23 set) changes no register. It takes a snapshot of the addressed register. The next frame shifts out that value in bits 15:0, with bits 23:16 zero. Any committed write frame sets the pending return value to zero.
- R5: The read addresses are:
  - data 0x00+ch
  - converter control 0x04+ch
  - gain 0x08+ch
  - offset 0x0C+ch
  - slew 0x14+ch
  - main 0x19
  - boost supply 0x1A

  Control words read back zero-extended to 16 bits.
- R6: A frame whose bit count is not 24 when CS_N rises is discarded. It changes no register and keeps the pending return value.
- R7: The no-operation frame 0x1CE000 changes no register.
- R8: spi_miso_oe is low while CS_N is high and high while CS_N is low. MISO presents the first return bit before the first SCLK edge and advances on each SCLK falling edge.
- R9: After reset every register is zero, except the offset words, which are 0x8000. The pending return value is zero.
- R10: If the frame that carries the read data is itself a write to the register being read, the old snapshot is returned and the new value is stored.
- R11: Write addresses outside the listed groups are ignored. The clear-code reads (0x10+ch), the status read (0x18) and the reads of 0x1B to 0x1F return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_sclk | input | 1 | Serial clock, idle low |
| spi_cs_n | input | 1 | Active-low chip-select, frames the transfer |
| spi_mosi | input | 1 | Serial data in |
| spi_miso | output | 1 | Serial data out |
| spi_miso_oe | output | 1 | Output enable for the MISO pad driver |
| ch_data_o | output | NCH*16 | Per-channel output codes, channel 0 in the low bits |
| ch_gain_o | output | NCH*16 | Per-channel gain words |
| ch_offset_o | output | NCH*16 | Per-channel offset words |
| ch_slew_o | output | NCH*13 | Per-channel slew control words |
| ch_dacctl_o | output | NCH*13 | Per-channel converter control words |
| main_ctl_o | output | 13 | Global main control word |
| dcdc_ctl_o | output | 13 | Global boost-supply control word |
| sw_strobe_o | output | 1 | One-clock pulse on a software sub-register write |
| sw_word_o | output | 13 | Contents of the last software sub-register write |

## Verification
The case that matters is a single frame that does two jobs at once. It shifts out the snapshot taken by the previous read, and when CS_N rises it also commits a write to that same register. The bench provokes this by writing a known code, reading its address, and then sending a new write to the same channel as the filler frame. It passes only if the returned bits hold the old code while the output bus already shows the new one. It also checks that a discarded short frame between a read and its filler leaves the pending snapshot intact.

// File: rtl/quad_dac_pkg.sv
`timescale 1ns/1ps
package quad_dac_pkg;
   localparam int DW         = 16;
   localparam int FRAME_BITS = 24;
   localparam int AW         = 5;
   localparam int SEL_W      = 3;
   localparam int CW         = DW - SEL_W;

   typedef enum logic [SEL_W-1:0] {
      SUB_SLEW   = 3'd0,
      SUB_MAIN   = 3'd1,
      SUB_DACCTL = 3'd2,
      SUB_DCDC   = 3'd3,
      SUB_SOFT   = 3'd4
   } ctl_sel_e;

   // write groups: address bits 4:2
   localparam logic [2:0] WGRP_DATA = 3'b000;
   localparam logic [2:0] WGRP_GAIN = 3'b010;
   localparam logic [2:0] WGRP_OFFS = 3'b100;
   localparam logic [2:0] WGRP_CTRL = 3'b111;

   // read groups: address bits 4:2
   localparam logic [2:0] RGRP_DATA = 3'd0;
   localparam logic [2:0] RGRP_CTRL = 3'd1;
   localparam logic [2:0] RGRP_GAIN = 3'd2;
   localparam logic [2:0] RGRP_OFFS = 3'd3;
   localparam logic [2:0] RGRP_SLEW = 3'd5;
   localparam logic [2:0] RGRP_GLOB = 3'd6;

   localparam logic [1:0] RGLB_MAIN = 2'd1;
   localparam logic [1:0] RGLB_DCDC = 2'd2;

   localparam logic [FRAME_BITS-1:0] NOP_FRAME = 24'h1CE000;
endpackage

// File: rtl/spi_sync.sv
`timescale 1ns/1ps
module spi_sync #(
   parameter int         W       = 3,
   parameter int         STAGES  = 2,
   parameter logic [W-1:0] RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] din,
   output logic [W-1:0] dout
);
   logic [W-1:0] pipe [STAGES];

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)      pipe[s] <= RST_VAL;
         else if (s == 0) pipe[s] <= din;
         else             pipe[s] <= pipe[(s == 0) ? 0 : s-1];
      end
   end

   assign dout = pipe[STAGES-1];
endmodule

// File: rtl/spi_frame_shifter.sv
`timescale 1ns/1ps
module spi_frame_shifter
   import quad_dac_pkg::*;
#(
   parameter int SYNC_STAGES = 2
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  spi_sclk,
   input  logic                  spi_cs_n,
   input  logic                  spi_mosi,
   input  logic [DW-1:0]         ret_word,
   output logic                  spi_miso,
   output logic                  spi_miso_oe,
   output logic                  frame_valid,
   output logic [FRAME_BITS-1:0] frame_o
);
   localparam int CNT_W = $clog2(FRAME_BITS + 2);
   localparam logic [CNT_W-1:0] CNT_MAX  = '1;
   localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FRAME_BITS);
   localparam int PAD_W = FRAME_BITS - DW;

   logic [2:0] sync_v;
   logic sclk_s, cs_s, mosi_s, sclk_q, cs_q;
   logic sclk_rise, sclk_fall, cs_rise, cs_fall;
   logic [FRAME_BITS-1:0] rx_sr, tx_sr;
   logic [CNT_W-1:0] bit_cnt;

   spi_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b010)) u_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .din  ({spi_sclk, spi_cs_n, spi_mosi}),
      .dout (sync_v)
   );
   assign {sclk_s, cs_s, mosi_s} = sync_v;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sclk_q <= 1'b0;
         cs_q   <= 1'b1;
      end else begin
         sclk_q <= sclk_s;
         cs_q   <= cs_s;
      end
   end

   assign sclk_rise = sclk_s & ~sclk_q;
   assign sclk_fall = ~sclk_s & sclk_q;
   assign cs_rise   = cs_s & ~cs_q;
   assign cs_fall   = ~cs_s & cs_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rx_sr       <= '0;
         tx_sr       <= '0;
         bit_cnt     <= '0;
         frame_valid <= 1'b0;
         frame_o     <= '0;
      end else begin
         frame_valid <= 1'b0;
         if (cs_fall) begin
            bit_cnt <= '0;
            tx_sr   <= {{PAD_W{1'b0}}, ret_word};
         end else if (!cs_s) begin
            if (sclk_rise) begin
               rx_sr <= {rx_sr[FRAME_BITS-2:0], mosi_s};
               if (bit_cnt != CNT_MAX) bit_cnt <= bit_cnt + 1'b1;
            end
            if (sclk_fall) tx_sr <= {tx_sr[FRAME_BITS-2:0], 1'b0};
         end
         if (cs_rise && bit_cnt == CNT_FULL) begin
            frame_valid <= 1'b1;
            frame_o     <= rx_sr;
         end
      end
   end

   assign spi_miso    = tx_sr[FRAME_BITS-1];
   assign spi_miso_oe = ~cs_s;

   // a commit follows only a synchronized chip-select rise
   p_commit_on_cs_rise_r6: assert property (@(posedge clk) disable iff (!rst_n)
      frame_valid |-> ($past(cs_s) && !$past(cs_s, 2)));
   // return shifter is frozen while deselected
   p_tx_hold_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
      cs_s |=> $stable(tx_sr));
endmodule

// File: rtl/dac_regfile.sv
`timescale 1ns/1ps
module dac_regfile
   import quad_dac_pkg::*;
#(
   parameter int          NCH          = 4,
   parameter logic [DW-1:0] OFFSET_RESET = 16'h8000
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  frame_valid,
   input  logic [FRAME_BITS-1:0] frame,
   output logic [DW-1:0]         ret_word,
   output logic [NCH*DW-1:0]     data_o,
   output logic [NCH*DW-1:0]     gain_o,
   output logic [NCH*DW-1:0]     offs_o,
   output logic [NCH*CW-1:0]     slew_o,
   output logic [NCH*CW-1:0]     dctl_o,
   output logic [CW-1:0]         main_o,
   output logic [CW-1:0]         dcdc_o,
   output logic                  sw_strobe,
   output logic [CW-1:0]         sw_word
);
   logic            rd_f, wr_v, ctl_wr;
   logic [AW-1:0]   addr;
   logic [2:0]      grp;
   logic [1:0]      chn;
   logic [DW-1:0]   wd;
   logic [SEL_W-1:0] sel;
   logic [CW-1:0]   pay;
   logic [DW-1:0]   rd_val;
   logic            nop_seen;

   assign rd_f   = frame[FRAME_BITS-1];
   assign addr   = frame[DW+AW-1:DW];
   assign wd     = frame[DW-1:0];
   assign grp    = addr[4:2];
   assign chn    = addr[1:0];
   assign sel    = wd[DW-1:CW];
   assign pay    = wd[CW-1:0];
   assign wr_v   = frame_valid & ~rd_f;
   assign ctl_wr = wr_v && grp == WGRP_CTRL;
   assign nop_seen = frame_valid && frame == NOP_FRAME;

   for (genvar g = 0; g < NCH; g++) begin : g_ch
      logic hit;
      logic [DW-1:0] data_q, gain_q, offs_q;
      logic [CW-1:0] slew_q, dctl_q;
      assign hit = wr_v && chn == 2'(g);
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            data_q <= '0;
            gain_q <= '0;
            offs_q <= OFFSET_RESET;
            slew_q <= '0;
            dctl_q <= '0;
         end else if (hit) begin
            case (grp)
               WGRP_DATA: data_q <= wd;
               WGRP_GAIN: gain_q <= wd;
               WGRP_OFFS: offs_q <= wd;
               WGRP_CTRL: begin
                  if (sel == SUB_SLEW)   slew_q <= pay;
                  if (sel == SUB_DACCTL) dctl_q <= pay;
               end
               default: ;
            endcase
         end
      end
      assign data_o[g*DW +: DW] = data_q;
      assign gain_o[g*DW +: DW] = gain_q;
      assign offs_o[g*DW +: DW] = offs_q;
      assign slew_o[g*CW +: CW] = slew_q;
      assign dctl_o[g*CW +: CW] = dctl_q;
   end

   always_comb begin
      rd_val = '0;
      for (int g = 0; g < NCH; g++) begin
         if (chn == 2'(g)) begin
            case (grp)
               RGRP_DATA: rd_val = data_o[g*DW +: DW];
               RGRP_CTRL: rd_val = DW'(dctl_o[g*CW +: CW]);
               RGRP_GAIN: rd_val = gain_o[g*DW +: DW];
               RGRP_OFFS: rd_val = offs_o[g*DW +: DW];
               RGRP_SLEW: rd_val = DW'(slew_o[g*CW +: CW]);
               default: ;
            endcase
         end
      end
      if (grp == RGRP_GLOB) begin
         if (chn == RGLB_MAIN) rd_val = DW'(main_o);
         if (chn == RGLB_DCDC) rd_val = DW'(dcdc_o);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         main_o    <= '0;
         dcdc_o    <= '0;
         sw_strobe <= 1'b0;
         sw_word   <= '0;
         ret_word  <= '0;
      end else begin
         sw_strobe <= ctl_wr && sel == SUB_SOFT;
         if (ctl_wr && sel == SUB_MAIN) main_o  <= pay;
         if (ctl_wr && sel == SUB_DCDC) dcdc_o  <= pay;
         if (ctl_wr && sel == SUB_SOFT) sw_word <= pay;
         if (frame_valid) ret_word <= rd_f ? rd_val : '0;
      end
   end

   // a read request never alters stored words
   p_read_no_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (frame_valid && rd_f) |=> ($stable(data_o) && $stable(gain_o) && $stable(offs_o)
                                 && $stable(slew_o) && $stable(dctl_o)));
   // a committed write leaves nothing pending for return
   p_write_clears_ret_r4: assert property (@(posedge clk) disable iff (!rst_n)
      wr_v |=> ret_word == '0);
   // registers move only on a committed frame
   p_idle_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !frame_valid |=> ($stable(data_o) && $stable(offs_o) && $stable(main_o) && $stable(ret_word)));
   // the filler frame is inert
   p_nop_inert_r7: assert property (@(posedge clk) disable iff (!rst_n)
      nop_seen |=> ($stable(data_o) && $stable(slew_o) && $stable(dctl_o)
                    && $stable(main_o) && $stable(dcdc_o) && !sw_strobe));
   // software pulse lasts one clock
   p_sw_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
      sw_strobe |=> !sw_strobe);
endmodule

// File: rtl/quad_dac_spi_if.sv
`timescale 1ns/1ps
module quad_dac_spi_if
   import quad_dac_pkg::*;
#(
   parameter int          NCH          = 4,
   parameter int          SYNC_STAGES  = 2,
   parameter logic [15:0] OFFSET_RESET = 16'h8000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              spi_sclk,
   input  logic              spi_cs_n,
   input  logic              spi_mosi,
   output logic              spi_miso,
   output logic              spi_miso_oe,
   output logic [NCH*16-1:0] ch_data_o,
   output logic [NCH*16-1:0] ch_gain_o,
   output logic [NCH*16-1:0] ch_offset_o,
   output logic [NCH*13-1:0] ch_slew_o,
   output logic [NCH*13-1:0] ch_dacctl_o,
   output logic [12:0]       main_ctl_o,
   output logic [12:0]       dcdc_ctl_o,
   output logic              sw_strobe_o,
   output logic [12:0]       sw_word_o
);
   if (NCH < 1 || NCH > 4) begin : g_bad_nch
      $error("NCH must lie in 1..4, channel select is two address bits");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end

   logic                  frame_valid;
   logic [FRAME_BITS-1:0] frame;
   logic [DW-1:0]         ret_word;

   spi_frame_shifter #(.SYNC_STAGES(SYNC_STAGES)) u_shift (
      .clk        (clk),
      .rst_n      (rst_n),
      .spi_sclk   (spi_sclk),
      .spi_cs_n   (spi_cs_n),
      .spi_mosi   (spi_mosi),
      .ret_word   (ret_word),
      .spi_miso   (spi_miso),
      .spi_miso_oe(spi_miso_oe),
      .frame_valid(frame_valid),
      .frame_o    (frame)
   );

   dac_regfile #(.NCH(NCH), .OFFSET_RESET(OFFSET_RESET)) u_regs (
      .clk        (clk),
      .rst_n      (rst_n),
      .frame_valid(frame_valid),
      .frame      (frame),
      .ret_word   (ret_word),
      .data_o     (ch_data_o),
      .gain_o     (ch_gain_o),
      .offs_o     (ch_offset_o),
      .slew_o     (ch_slew_o),
      .dctl_o     (ch_dacctl_o),
      .main_o     (main_ctl_o),
      .dcdc_o     (dcdc_ctl_o),
      .sw_strobe  (sw_strobe_o),
      .sw_word    (sw_word_o)
   );
endmodule

// File: tb/quad_dac_spi_if_bench.sv
`timescale 1ns/1ps
module quad_dac_spi_if_bench;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic spi_sclk = 1'b0, spi_cs_n = 1'b1, spi_mosi = 1'b0;
   logic spi_miso, spi_miso_oe;
   logic [63:0] ch_data_o, ch_gain_o, ch_offset_o;
   logic [51:0] ch_slew_o, ch_dacctl_o;
   logic [12:0] main_ctl_o, dcdc_ctl_o, sw_word_o;
   logic sw_strobe_o;

   int checks = 0, failures = 0, sw_pulses = 0;
   bit done = 1'b0;

   logic [15:0] e_data [4], e_gain [4], e_offs [4];
   logic [12:0] e_slew [4], e_dctl [4], e_main, e_dcdc;

   always #2.5 clk = ~clk;

   quad_dac_spi_if u_quad_dac_spi_if (
      .clk(clk), .rst_n(rst_n), .spi_sclk(spi_sclk), .spi_cs_n(spi_cs_n),
      .spi_mosi(spi_mosi), .spi_miso(spi_miso), .spi_miso_oe(spi_miso_oe),
      .ch_data_o(ch_data_o), .ch_gain_o(ch_gain_o), .ch_offset_o(ch_offset_o),
      .ch_slew_o(ch_slew_o), .ch_dacctl_o(ch_dacctl_o), .main_ctl_o(main_ctl_o),
      .dcdc_ctl_o(dcdc_ctl_o), .sw_strobe_o(sw_strobe_o), .sw_word_o(sw_word_o)
   );

   always @(posedge clk) if (sw_strobe_o) sw_pulses++;

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic xfer(input logic [23:0] tx, input int nbits, output logic [23:0] rx);
      rx = '0;
      spi_cs_n = 1'b0;
      #80;
      for (int i = 0; i < nbits; i++) begin
         spi_mosi = (i < 24) ? tx[23-i] : 1'b0;
         #40;
         if (i < 24) rx[23-i] = spi_miso;
         spi_sclk = 1'b1;
         #40;
         spi_sclk = 1'b0;
      end
      #40;
      spi_cs_n = 1'b1;
      #200;
   endtask

   task automatic wr(input logic [4:0] a, input logic [15:0] d);
      logic [23:0] r;
      xfer({3'b000, a, d}, 24, r);
   endtask

   task automatic rd(input logic [4:0] a, output logic [23:0] r);
      logic [23:0] d;
      xfer({1'b1, 2'b00, a, 16'h0000}, 24, d);
      xfer(24'h1CE000, 24, r);
   endtask

   task automatic check_all(input string req);
      for (int c = 0; c < 4; c++) begin
         check(req, ch_data_o[c*16 +: 16], e_data[c]);
         check(req, ch_gain_o[c*16 +: 16], e_gain[c]);
         check(req, ch_offset_o[c*16 +: 16], e_offs[c]);
         check(req, ch_slew_o[c*13 +: 13], e_slew[c]);
         check(req, ch_dacctl_o[c*13 +: 13], e_dctl[c]);
      end
      check(req, main_ctl_o, e_main);
      check(req, dcdc_ctl_o, e_dcdc);
   endtask

   task automatic t_reset;
      logic [23:0] r;
      for (int c = 0; c < 4; c++) begin
         e_data[c] = 16'h0; e_gain[c] = 16'h0; e_offs[c] = 16'h8000;
         e_slew[c] = '0; e_dctl[c] = '0;
      end
      e_main = '0; e_dcdc = '0;
      check_all("R9 reset values");
      check("R9 sw_word reset", sw_word_o, 13'h0);
      check("R8 oe idle", spi_miso_oe, 1'b0);
      xfer(24'h1CE000, 24, r);
      check("R9 pending return after reset", r, 24'h0);
   endtask

   task automatic t_writes;
      for (int c = 0; c < 4; c++) begin
         e_data[c] = 16'h1000 * (c + 1) + 16'h0A5;
         e_gain[c] = 16'hF00F ^ 16'(c * 16'h0111);
         e_offs[c] = 16'h7F00 + 16'(c);
         wr(5'(c), e_data[c]);
         wr(5'h08 + 5'(c), e_gain[c]);
         wr(5'h10 + 5'(c), e_offs[c]);
      end
      check_all("R2 data gain offset writes");
      // R1: bits 22:21 set have no effect
      begin
         logic [23:0] r;
         xfer({3'b011, 5'h01, 16'hBEEF}, 24, r);
         e_data[1] = 16'hBEEF;
      end
      check("R1 ignored bits 22:21", ch_data_o[16 +: 16], 16'hBEEF);
   endtask

   task automatic t_control;
      int p0;
      wr(5'h1E, {3'd0, 13'h1ABC}); e_slew[2] = 13'h1ABC;
      wr(5'h1F, {3'd2, 13'h0123}); e_dctl[3] = 13'h0123;
      wr(5'h1D, {3'd1, 13'h0F0F}); e_main = 13'h0F0F;
      wr(5'h1C, {3'd3, 13'h0055}); e_dcdc = 13'h0055;
      check_all("R3 control sub-register writes");
      p0 = sw_pulses;
      wr(5'h1F, {3'd4, 13'h1357});
      check("R3 software pulse count", 32'(sw_pulses - p0), 32'd1);
      check("R3 software word", sw_word_o, 13'h1357);
      wr(5'h1E, {3'd5, 13'h1FFF});
      wr(5'h1D, {3'd6, 13'h1FFF});
      check_all("R3 selectors 5 and 6 ignored");
   endtask

   task automatic t_reads;
      logic [23:0] r;
      rd(5'h02, r);
      check("R4 read data ch2", r, {8'h00, e_data[2]});
      check_all("R4 read frame writes nothing");
      rd(5'h07, r);  check("R5 read ctl ch3", r, {8'h00, 3'b000, e_dctl[3]});
      rd(5'h09, r);  check("R5 read gain ch1", r, {8'h00, e_gain[1]});
      rd(5'h0D, r);  check("R5 read offset ch1", r, {8'h00, e_offs[1]});
      rd(5'h16, r);  check("R5 read slew ch2", r, {8'h00, 3'b000, e_slew[2]});
      rd(5'h19, r);  check("R5 read main", r, {8'h00, 3'b000, e_main});
      rd(5'h1A, r);  check("R5 read dcdc", r, {8'h00, 3'b000, e_dcdc});
      rd(5'h10, r);  check("R11 read clear code", r, 24'h0);
      rd(5'h18, r);  check("R11 read status", r, 24'h0);
      rd(5'h1F, r);  check("R11 read unmapped", r, 24'h0);
      wr(5'h0A, e_gain[2]);
      xfer(24'h1CE000, 24, r);
      check("R4 write zeroes pending return", r, 24'h0);
   endtask

   task automatic t_badlen;
      logic [23:0] r, d;
      xfer({3'b000, 5'h00, 16'hDEAD}, 23, d);
      check("R6 23-bit frame discarded", ch_data_o[15:0], e_data[0]);
      xfer({3'b000, 5'h00, 16'hDEAD}, 25, d);
      check("R6 25-bit frame discarded", ch_data_o[15:0], e_data[0]);
      xfer({1'b1, 2'b00, 5'h08, 16'h0}, 24, d);
      xfer({3'b000, 5'h00, 16'h4444}, 10, d);
      xfer(24'h1CE000, 24, r);
      check("R6 pending return survives bad frame", r, {8'h00, e_gain[0]});
      check_all("R6 no register changed");
   endtask

   task automatic t_nop_unmapped;
      logic [23:0] r;
      xfer(24'h1CE000, 24, r);
      check_all("R7 no-operation frame");
      wr(5'h04, 16'hAAAA);
      wr(5'h18, 16'h5555);
      wr(5'h0C, 16'h1234);
      check_all("R11 unmapped writes ignored");
   endtask

   task automatic t_miso_oe;
      check("R8 oe low while deselected", spi_miso_oe, 1'b0);
      spi_cs_n = 1'b0;
      #80;
      check("R8 oe high while selected", spi_miso_oe, 1'b1);
      spi_cs_n = 1'b1;
      #200;
      check("R8 oe low after deselect", spi_miso_oe, 1'b0);
   endtask

   task automatic t_same_frame;
      logic [23:0] r, d;
      wr(5'h00, 16'h1111);
      xfer({1'b1, 2'b00, 5'h00, 16'h0}, 24, d);
      xfer({3'b000, 5'h00, 16'h2222}, 24, r);
      e_data[0] = 16'h2222;
      check("R10 old snapshot returned", r, 24'h001111);
      check("R10 new value stored", ch_data_o[15:0], 16'h2222);
   endtask

   initial begin
      #50 rst_n = 1'b1;
      #100;
      t_reset();
      t_writes();
      t_control();
      t_reads();
      t_badlen();
      t_nop_unmapped();
      t_miso_oe();
      t_same_frame();
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      #500000;
      if (!done) begin
         checks++;
         failures++;
         $display("FAIL watchdog all-requirements actual=timeout expected=completion");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end
endmodule